// File: doc/BRIEF.md
# Flash Command and Status Controller

This block is a cycle-based model of the control engine that sits behind a parallel NOR flash bus. Commands arrive as words written on a synchronous write strobe. Some commands take one bus cycle and some take two. Word program and sector erase are timed by parameterised cycle counters rather than real delays, and either one can be suspended and resumed. The cell array is a small behavioural memory. An erased word reads all ones, and programming can only clear bits.

An 8-bit status byte reports the state of the engine. Bit 7 is ready. Bit 6 means erase suspended and bit 2 means program suspended. Bit 5 is an erase error, bit 4 a program error and bit 3 a low programming supply. Bit 1 means an operation aborted on a protected sector, and bit 0 always reads 0. The read port returns one of three things, chosen by the last accepted mode command: array data, status, or identification words. The caller supplies the protection state of the addressed sector through a lock input. The programming supply is reduced to a digital ok input.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: After reset the read mode is array, every word reads FFFFh and the status byte is 80h. In status mode a read returns {00h, status}.
- R2: Writing 40h and then a data word at the target address starts a program. SR7 reads 0 until the program completes, which happens exactly PROG_CYC clocks after the confirm write. The stored word becomes the old value AND the new value.
- R3: Writing 20h and then D0h at an address inside a sector starts an erase. ERASE_CYC clocks after the confirm, every word of that sector reads FFFFh and other sectors are unchanged. The sector is selected by the top SEC_BITS address bits.
- R4: 70h selects status reads, FFh selects array reads, and SR0 reads 0.
- R5: SR5, SR4, SR3 and SR1 stay set across later successful operations. They are cleared only by 50h or by reset, and 50h leaves SR7 set.
- R6: If the lock input is high on the confirm cycle, the program or erase aborts. SR1 is set, SR7 stays 1, the array is unchanged and reads return status.
- R7: If vpp_ok is low on the confirm cycle, the operation aborts with the array unchanged and SR7 at 1. A program abort sets SR3 and SR4 (status 98h). An erase abort sets SR3 and SR5.
- R8: An erase setup followed by any word other than D0h sets SR5, SR4, SR3 and SR1 together, giving status BAh.
- R9: While a program or erase runs, only 70h, B0h and D0h are acted upon. An FFh written then leaves reads returning busy status.
- R10: B0h during a program freezes its counter. SUSP_LAT clocks later, SR7 and SR2 read 1 and the array can be read. D0h resumes the program, clears SR2, and the program finishes after the cycles that remained.
- R11: B0h during an erase sets SR7 and SR6 after SUSP_LAT clocks. While the erase is suspended, 20h is ignored, and a program to another sector runs and then returns to the erase-suspended state with SR6 still set. D0h resumes the erase, which finishes after its remaining cycles.
- R12: 90h selects identification reads: rd_addr bit 0 = 0 returns MFR_ID and 1 returns DEV_ID. 98h selects query reads, which return 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one word per clock |
| wr_addr | input | AW | Write address |
| wr_data | input | 16 | Write data; the command code is bits 7:0 |
| sec_locked | input | 1 | Protection state of the sector addressed by wr_addr |
| vpp_ok | input | 1 | Programming supply is adequate |
| rd_addr | input | AW | Read address |
| rd_data | output | 16 | Read result for the current read mode |

## Verification
A state that fails to leave busy, or that leaves it early, shows at once in SR7. The bench measures the busy window in clocks against PROG_CYC, ERASE_CYC and SUSP_LAT, so an off-by-one in a counter or a lost frozen count shows as a wrong cycle count. A wrong state for the command filter shows on the next read: a stray FFh switches to array data, or a stray 20h sets error bits. A wrong array update is caught by reading back words both inside and outside the target sector right after each operation.

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl #(
  parameter int AW        = 8,
  parameter int SEC_BITS  = 3,
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 20,
  parameter int SUSP_LAT  = 3,
  parameter logic [15:0] MFR_ID = 16'h001F,
  parameter logic [15:0] DEV_ID = 16'h03A1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [15:0]   wr_data,
  input  logic          sec_locked,
  input  logic          vpp_ok,
  input  logic [AW-1:0] rd_addr,
  output logic [15:0]   rd_data
);
  localparam int DEPTH = 1 << AW;
  localparam int OW    = AW - SEC_BITS;
  localparam int WPS   = 1 << OW;
  localparam int PCW   = $clog2(PROG_CYC + 1);
  localparam int ECW   = $clog2(ERASE_CYC + 1);
  localparam int LW    = $clog2(SUSP_LAT + 1);

  typedef enum logic [2:0] {S_IDLE, S_PSET, S_ESET, S_PROG, S_ERASE, S_PSUS, S_ESUS} st_t;
  typedef enum logic [1:0] {M_ARR, M_STAT, M_ID, M_CFI} rm_t;

  st_t st;
  rm_t rm;
  logic [7:0]  sr;
  logic        esus;
  logic [AW-1:0] paddr;
  logic [15:0] pdata;
  logic [PCW-1:0] pcnt;
  logic [SEC_BITS-1:0] esec;
  logic [ECW-1:0] ecnt;
  logic [LW-1:0]  lat;
  logic [15:0] mem [DEPTH];

  wire [7:0] cmd  = wr_data[7:0];
  wire st_t  back = esus ? S_ESUS : S_IDLE;

  assign rd_data = (rm == M_ARR)  ? mem[rd_addr] :
                   (rm == M_STAT) ? {8'h00, sr} :
                   (rm == M_ID)   ? (rd_addr[0] ? DEV_ID : MFR_ID) : 16'h0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; rm <= M_ARR; sr <= 8'h80; esus <= 1'b0;
      paddr <= '0; pdata <= '0; pcnt <= '0; esec <= '0; ecnt <= '0; lat <= '0;
      for (int i = 0; i < DEPTH; i++) mem[AW'(i)] <= '1;
    end else begin
      case (st)
        S_IDLE: if (wr_en) begin
          case (cmd)
            8'hFF: rm <= M_ARR;
            8'h70: rm <= M_STAT;
            8'h50: begin sr[5] <= 1'b0; sr[4] <= 1'b0; sr[3] <= 1'b0; sr[1] <= 1'b0; end
            8'h90: rm <= M_ID;
            8'h98: rm <= M_CFI;
            8'h40: begin st <= S_PSET; rm <= M_STAT; end
            8'h20: begin st <= S_ESET; rm <= M_STAT; end
            default: ;
          endcase
        end
        S_PSET: if (wr_en) begin
          rm <= M_STAT;
          if (sec_locked) begin sr[1] <= 1'b1; st <= back; end
          else if (!vpp_ok) begin sr[3] <= 1'b1; sr[4] <= 1'b1; st <= back; end
          else begin
            st <= S_PROG; sr[7] <= 1'b0; paddr <= wr_addr; pdata <= wr_data; pcnt <= PCW'(PROG_CYC);
          end
        end
        S_ESET: if (wr_en) begin
          st <= S_IDLE;
          if (cmd != 8'hD0) begin sr[5] <= 1'b1; sr[4] <= 1'b1; sr[3] <= 1'b1; sr[1] <= 1'b1; end
          else if (sec_locked) sr[1] <= 1'b1;
          else if (!vpp_ok) begin sr[3] <= 1'b1; sr[5] <= 1'b1; end
          else begin
            st <= S_ERASE; sr[7] <= 1'b0; esec <= wr_addr[AW-1:OW]; ecnt <= ECW'(ERASE_CYC);
          end
        end
        S_PROG: begin
          if (wr_en && cmd == 8'hB0) begin st <= S_PSUS; lat <= LW'(SUSP_LAT); end
          else begin
            if (wr_en && cmd == 8'h70) rm <= M_STAT;
            if (pcnt == PCW'(1)) begin
              mem[paddr] <= mem[paddr] & pdata; sr[7] <= 1'b1; st <= back;
            end else pcnt <= pcnt - PCW'(1);
          end
        end
        S_ERASE: begin
          if (wr_en && cmd == 8'hB0) begin st <= S_ESUS; esus <= 1'b1; lat <= LW'(SUSP_LAT); end
          else begin
            if (wr_en && cmd == 8'h70) rm <= M_STAT;
            if (ecnt == ECW'(1)) begin
              for (int i = 0; i < WPS; i++) mem[{esec, OW'(i)}] <= '1;
              sr[7] <= 1'b1; st <= S_IDLE;
            end else ecnt <= ecnt - ECW'(1);
          end
        end
        S_PSUS: begin
          if (lat != '0) begin
            lat <= lat - LW'(1);
            if (lat == LW'(1)) begin sr[7] <= 1'b1; sr[2] <= 1'b1; end
          end else if (wr_en) begin
            case (cmd)
              8'hFF: rm <= M_ARR;
              8'h70: rm <= M_STAT;
              8'h90: rm <= M_ID;
              8'hD0: begin st <= S_PROG; sr[2] <= 1'b0; sr[7] <= 1'b0; rm <= M_STAT; end
              default: ;
            endcase
          end
        end
        S_ESUS: begin
          if (lat != '0) begin
            lat <= lat - LW'(1);
            if (lat == LW'(1)) begin sr[7] <= 1'b1; sr[6] <= 1'b1; end
          end else if (wr_en) begin
            case (cmd)
              8'hFF: rm <= M_ARR;
              8'h70: rm <= M_STAT;
              8'h90: rm <= M_ID;
              8'h98: rm <= M_CFI;
              8'h40: begin st <= S_PSET; rm <= M_STAT; end
              8'hD0: begin st <= S_ERASE; esus <= 1'b0; sr[6] <= 1'b0; sr[7] <= 1'b0; rm <= M_STAT; end
              default: ;
            endcase
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  wire [3:0] errs = {sr[5], sr[4], sr[3], sr[1]};

  p_sticky_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(errs) & ~errs)) |-> $past(wr_en && st == S_IDLE && wr_data[7:0] == 8'h50));

  p_busy_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PROG || st == S_ERASE) |-> !sr[7]);

  p_prog_susp_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sr[2] |-> (sr[7] && st == S_PSUS));

  p_erase_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sr[6] |-> esus);

  p_bad_seq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ESET && wr_en && wr_data[7:0] != 8'hD0) |=> (sr[5] && sr[4] && sr[3] && sr[1]));

  p_lock_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PSET && wr_en && sec_locked) |=> (sr[1] && rm == M_STAT && st != S_PROG));
endmodule

// File: tb/sim_nor_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_nor_cmd_ctrl;
  localparam int AW = 8;
  localparam int PROG_CYC = 6;
  localparam int ERASE_CYC = 20;
  localparam int SUSP_LAT = 3;
  localparam logic [15:0] MFR = 16'h001F;
  localparam logic [15:0] DEV = 16'h03A1;

  logic clk = 0, rst_n = 0, wr_en = 0, sec_locked = 0, vpp_ok = 1;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nor_cmd_ctrl #(.AW(AW), .SEC_BITS(3), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC),
                 .SUSP_LAT(SUSP_LAT), .MFR_ID(MFR), .DEV_ID(DEV)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sec_locked(sec_locked), .vpp_ok(vpp_ok), .rd_addr(rd_addr), .rd_data(rd_data));

  typedef struct { logic [AW-1:0] a; logic [15:0] e; string tag; } item_t;
  item_t q[$];
  bit mon_busy = 0;

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (q.size() > 0) begin
      item_t it;
      mon_busy = 1;
      it = q.pop_front();
      rd_addr = it.a;
      #1;
      cmp(it.tag, {16'h0, rd_data}, {16'h0, it.e});
      mon_busy = 0;
    end
  end

  task automatic expect_rd(logic [AW-1:0] a, logic [15:0] e, string tag);
    q.push_back('{a, e, tag});
    wait (q.size() == 0 && !mon_busy);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    #1;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!rd_data[7] && n < 1000) begin
      @(negedge clk); #1; n++;
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    expect_rd(8'h05, 16'hFFFF, "R1 erased after reset");
    wr(0, 16'h0070);
    expect_rd(0, 16'h0080, "R1 R4 status after reset");

    // R2 program
    wr(0, 16'h0040); wr(8'h05, 16'h1234);
    cmp("R2 busy after confirm", {16'h0, rd_data}, 32'h0000);
    wait_ready(n);
    cmp("R2 program cycles", n, PROG_CYC);
    cmp("R2 ready status", {16'h0, rd_data}, 32'h0080);
    wr(0, 16'h0040); wr(8'h05, 16'hFF0F); wait_ready(n);
    wr(0, 16'h0040); wr(8'h25, 16'h00FF); wait_ready(n);
    wr(0, 16'h00FF);
    expect_rd(8'h05, 16'h1204, "R2 AND of old and new");
    expect_rd(8'h25, 16'h00FF, "R2 second word");

    // R9 FF ignored while programming
    wr(0, 16'h0040); wr(8'h06, 16'h0000);
    wr(0, 16'h00FF);
    cmp("R9 FF ignored while busy", {16'h0, rd_data}, 32'h0000);
    wait_ready(n);
    wr(0, 16'h00FF);
    expect_rd(8'h06, 16'h0000, "R9 program completed");

    // R3 erase sector 0
    wr(0, 16'h0020); wr(8'h00, 16'h00D0);
    wait_ready(n);
    cmp("R3 erase cycles", n, ERASE_CYC);
    wr(0, 16'h00FF);
    expect_rd(8'h05, 16'hFFFF, "R3 sector word erased");
    expect_rd(8'h06, 16'hFFFF, "R3 sector word erased");
    expect_rd(8'h25, 16'h00FF, "R3 other sector kept");

    // R6 locked sector
    sec_locked = 1;
    wr(0, 16'h0040); wr(8'h40, 16'h0000);
    sec_locked = 0;
    cmp("R6 lock abort status", {16'h0, rd_data}, 32'h0082);
    wr(0, 16'h00FF);
    expect_rd(8'h40, 16'hFFFF, "R6 array unchanged");
    wr(0, 16'h0050); wr(0, 16'h0070);
    expect_rd(0, 16'h0080, "R5 clear status");

    // R7 supply low
    vpp_ok = 0;
    wr(0, 16'h0040); wr(8'h41, 16'h0000);
    cmp("R7 program supply abort", {16'h0, rd_data}, 32'h0098);
    wr(0, 16'h0020); wr(8'h40, 16'h00D0);
    cmp("R7 erase supply abort", {16'h0, rd_data}, 32'h00B8);
    vpp_ok = 1;
    wr(0, 16'h0040); wr(8'h42, 16'h0000); wait_ready(n);
    cmp("R5 errors sticky after success", {16'h0, rd_data}, 32'h00B8);
    wr(0, 16'h00FF);
    expect_rd(8'h41, 16'hFFFF, "R7 array unchanged");
    expect_rd(8'h42, 16'h0000, "R5 later program done");
    wr(0, 16'h0050); wr(0, 16'h0070);
    expect_rd(0, 16'h0080, "R5 cleared again");

    // R8 invalid sequence
    wr(0, 16'h0020); wr(8'h40, 16'h00FF);
    cmp("R8 invalid sequence", {16'h0, rd_data}, 32'h00BA);
    wr(0, 16'h0050); wr(0, 16'h0070);
    expect_rd(0, 16'h0080, "R8 cleared");

    // R10 program suspend
    wr(0, 16'h0040); wr(8'h50, 16'h0000);
    wr(0, 16'h00B0);
    cmp("R10 still busy at suspend", {16'h0, rd_data}, 32'h0000);
    wait_ready(n);
    cmp("R10 suspend latency", n, SUSP_LAT);
    cmp("R10 suspended status", {16'h0, rd_data}, 32'h0084);
    wr(0, 16'h00FF);
    expect_rd(8'h50, 16'hFFFF, "R10 target not yet written");
    expect_rd(8'h42, 16'h0000, "R10 array readable");
    wr(0, 16'h00D0);
    cmp("R10 resumed busy", {16'h0, rd_data}, 32'h0000);
    wait_ready(n);
    cmp("R10 remaining cycles", n, PROG_CYC - 1);
    cmp("R10 suspend bit cleared", {16'h0, rd_data}, 32'h0080);
    wr(0, 16'h00FF);
    expect_rd(8'h50, 16'h0000, "R10 program finished");

    // R11 erase suspend
    wr(0, 16'h0020); wr(8'h40, 16'h00D0);
    wr(0, 16'h00B0);
    wait_ready(n);
    cmp("R11 suspend latency", n, SUSP_LAT);
    cmp("R11 erase suspended status", {16'h0, rd_data}, 32'h00C0);
    wr(0, 16'h0020); wr(0, 16'h0070);
    expect_rd(0, 16'h00C0, "R11 erase setup ignored");
    wr(0, 16'h0040); wr(8'h70, 16'h5555);
    cmp("R11 nested program busy", {16'h0, rd_data}, 32'h0040);
    wait_ready(n);
    cmp("R11 nested program cycles", n, PROG_CYC);
    cmp("R11 back to erase suspend", {16'h0, rd_data}, 32'h00C0);
    wr(0, 16'h00FF);
    expect_rd(8'h70, 16'h5555, "R11 nested program data");
    expect_rd(8'h42, 16'h0000, "R11 erase not done yet");
    wr(0, 16'h00D0);
    wait_ready(n);
    cmp("R11 erase remaining cycles", n, ERASE_CYC - 1);
    cmp("R11 erase done status", {16'h0, rd_data}, 32'h0080);
    wr(0, 16'h00FF);
    expect_rd(8'h42, 16'hFFFF, "R11 erased word");
    expect_rd(8'h50, 16'hFFFF, "R11 erased word");
    expect_rd(8'h70, 16'h5555, "R11 other sector kept");

    // R12 identification and query
    wr(0, 16'h0090);
    expect_rd(8'h00, MFR, "R12 maker id");
    expect_rd(8'h01, DEV, "R12 device id");
    wr(0, 16'h0098);
    expect_rd(8'h03, 16'h0000, "R12 query read");
    wr(0, 16'h00FF);
    expect_rd(8'h70, 16'h5555, "R4 array mode restored");

    finish_up();
  end
endmodule